// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits after the receive PHY. It watches the header of each 802.11 frame as the bytes arrive, one byte per strobe, and decides whether the frame goes up to the host. Each frame opens with five PHY bytes (three SIGNAL bytes and two SERVICE bytes). Then come the two frame-control bytes, the two duration bytes, the six-byte receiver address (RA) and the six-byte transmitter address (TA). The block classifies the frame from these fields.

Software programs three values through a small write-only register port: the station's own MAC address, the BSSID, and a 14-bit category mask. The mask has one bit per frame class. A frame is passed if any enabled class matches it. After the last TA byte, the block issues a single decision: a one-cycle valid pulse together with a pass bit. The parser rearms whenever a new frame start is signalled.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid_o` and `dec_pass_o` are low and all configuration registers hold zero, so every frame is dropped until the mask is written.
- R2: Byte 0 is the byte accepted in the cycle of `frame_start_i` or the first accepted byte after it. Bytes 5/6 are frame control, 9..14 are the RA and 15..20 are the TA. `dec_valid_o` is high for exactly one cycle, the cycle after byte 20 is accepted, whatever idle cycles lie between bytes.
- R3: Mask bit 9 (unicast-for-us) passes a frame whose RA equals the own MAC. RA byte k is compared with own-MAC byte k.
- R4: Mask bit 10 passes RA = FF:FF:FF:FF:FF:FF. Mask bit 11 passes RA = 00:00:00:00:00:00.
- R5: Mask bit 1 (all-multicast) passes an RA whose first three bytes are 01:00:5E, or whose first two bytes are 33:33.
- R6: Mask bit 12 (own beacon) passes a beacon whose TA equals the BSSID register. A beacon is frame-control byte 5 with bits [3:2] = 0 (type) and bits [7:4] = 8 (subtype).
- R7: Mask bit 4 passes any beacon (type 0, subtype 8) and any probe response (type 0, subtype 5), whatever the addresses.
- R8: Mask bit 5 passes every control frame (type 1). Mask bit 7 passes PS-Poll (type 1, subtype 10). Mask bit 8 passes probe request (type 0, subtype 4).
- R9: Mask bit 6 (other BSS) passes a data frame (type 2) whose TA differs from the BSSID register.
- R10: Mask bit 13 (monitor) passes every frame, whatever the other bits are.
- R11: Mask bits 0, 2 and 3 have no effect on the decision.
- R12: Register writes use `cfg_addr_i`. Address 0 holds own-MAC bytes 0..3 (byte 0 in bits 7:0). Address 1 holds own-MAC bytes 4..5 in bits 15:0, and upper bits are ignored. Addresses 2 and 3 hold the BSSID in the same layout. Address 4 holds the mask in bits 13:0.
- R13: A `frame_start_i` in the middle of a frame abandons the partial header. No decision is issued for the abandoned frame, and the new frame is parsed from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| frame_start_i | input | 1 | New frame begins; rearms the parser |
| byte_valid_i | input | 1 | `byte_i` carries a header byte |
| byte_i | input | 8 | Received byte |
| dec_valid_o | output | 1 | One-cycle decision strobe |
| dec_pass_o | output | 1 | Frame passes (meaningful with `dec_valid_o`) |

## Verification
Directed frames enable one mask bit at a time. Each is paired with a frame that nearly matches: an RA one byte off the own MAC, a multicast prefix off by one bit, a probe response against the own-beacon class, and a data frame from the own BSS against the other-BSS class. These pairs separate the address compares from the type and subtype decode. Mask values using only the unsupported bits show that they are ignored. A header abandoned partway shows that a restart discards stale bytes. The random phase mixes RA and TA pools (own, broadcast, zero, both multicast forms, random) with random masks and random strobe gaps. This exercises the OR across categories and the timing under stalls.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FLAG_W   = 14;
  localparam int MAC_W    = 48;
  localparam int CFG_AW   = 3;

  // mask bit positions (decoded by software)
  localparam int F_ALLMC   = 1;
  localparam int F_FCSERR  = 2;
  localparam int F_PLCPERR = 3;
  localparam int F_BCNPROM = 4;
  localparam int F_CTRL    = 5;
  localparam int F_OBSS    = 6;
  localparam int F_PSPOLL  = 7;
  localparam int F_PRBREQ  = 8;
  localparam int F_UCAST   = 9;
  localparam int F_BC_ONE  = 10;
  localparam int F_BC_ZERO = 11;
  localparam int F_MYBCN   = 12;
  localparam int F_MONITOR = 13;

  localparam logic [FLAG_W-1:0] USED_MASK =
    ~((FLAG_W'(1) << 0) | (FLAG_W'(1) << F_FCSERR) | (FLAG_W'(1) << F_PLCPERR));

  typedef enum logic [CFG_AW-1:0] {
    REG_OWN_LO = 3'd0,
    REG_OWN_HI = 3'd1,
    REG_BSS_LO = 3'd2,
    REG_BSS_HI = 3'd3,
    REG_MASK   = 3'd4
  } cfg_reg_e;

  localparam logic [1:0] T_MGMT = 2'd0;
  localparam logic [1:0] T_CTRL = 2'd1;
  localparam logic [1:0] T_DATA = 2'd2;
  localparam logic [3:0] S_BEACON = 4'd8;
  localparam logic [3:0] S_PRBRSP = 4'd5;
  localparam logic [3:0] S_PRBREQ = 4'd4;
  localparam logic [3:0] S_PSPOLL = 4'd10;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [MAC_W-1:0]  own_mac_o,
  output logic [MAC_W-1:0]  bssid_o,
  output logic [FLAG_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_mac_o <= '0;
      bssid_o   <= '0;
      mask_o    <= '0;
    end else if (we_i) begin
      case (cfg_reg_e'(addr_i))
        REG_OWN_LO: own_mac_o[31:0]  <= wdata_i;
        REG_OWN_HI: own_mac_o[47:32] <= wdata_i[15:0];
        REG_BSS_LO: bssid_o[31:0]    <= wdata_i;
        REG_BSS_HI: bssid_o[47:32]   <= wdata_i[15:0];
        REG_MASK:   mask_o           <= wdata_i[FLAG_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxf_hdr_parser.sv
module rxf_hdr_parser #(
  parameter int PHY_BYTES  = 5,
  parameter int ADDR_BYTES = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  valid_i,
  input  logic [7:0]            data_i,
  output logic [7:2]            fc_o,
  output logic [8*ADDR_BYTES-1:0] ra_o,
  output logic [8*ADDR_BYTES-1:0] ta_o,
  output logic                  done_o
);
  localparam int FC_IDX = PHY_BYTES;
  localparam int RA_IDX = PHY_BYTES + 4;
  localparam int TA_IDX = RA_IDX + ADDR_BYTES;
  localparam int LAST   = TA_IDX + ADDR_BYTES - 1;
  localparam int CW     = $clog2(LAST + 2);

  logic [CW-1:0] cnt_q, idx;
  logic          busy_q, take;

  assign idx  = start_i ? '0 : cnt_q;
  assign take = valid_i && (start_i || busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      fc_o   <= '0;
      ra_o   <= '0;
      ta_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
      if (take) begin
        cnt_q <= idx + 1'b1;
        if (idx == CW'(FC_IDX)) fc_o <= data_i[7:2];
        for (int k = 0; k < ADDR_BYTES; k++) begin
          if (idx == CW'(RA_IDX + k)) ra_o[8*k +: 8] <= data_i;
          if (idx == CW'(TA_IDX + k)) ta_o[8*k +: 8] <= data_i;
        end
        if (idx == CW'(LAST)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  logic [7:2]        fc_i,
  input  logic [MAC_W-1:0]  ra_i,
  input  logic [MAC_W-1:0]  ta_i,
  input  logic [MAC_W-1:0]  own_mac_i,
  input  logic [MAC_W-1:0]  bssid_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic              pass_o
);
  logic [1:0]        ftype;
  logic [3:0]        fsub;
  logic              is_bcn, ta_is_bss;
  logic [FLAG_W-1:0] hit;

  assign ftype     = fc_i[3:2];
  assign fsub      = fc_i[7:4];
  assign is_bcn    = (ftype == T_MGMT) && (fsub == S_BEACON);
  assign ta_is_bss = (ta_i == bssid_i);

  always_comb begin
    hit            = '0;
    hit[F_ALLMC]   = (ra_i[23:0] == 24'h5E_00_01) || (ra_i[15:0] == 16'h3333);
    hit[F_BCNPROM] = (ftype == T_MGMT) && ((fsub == S_BEACON) || (fsub == S_PRBRSP));
    hit[F_CTRL]    = (ftype == T_CTRL);
    hit[F_OBSS]    = (ftype == T_DATA) && !ta_is_bss;
    hit[F_PSPOLL]  = (ftype == T_CTRL) && (fsub == S_PSPOLL);
    hit[F_PRBREQ]  = (ftype == T_MGMT) && (fsub == S_PRBREQ);
    hit[F_UCAST]   = (ra_i == own_mac_i);
    hit[F_BC_ONE]  = &ra_i;
    hit[F_BC_ZERO] = ~|ra_i;
    hit[F_MYBCN]   = is_bcn && ta_is_bss;
    hit[F_MONITOR] = 1'b1;
  end

  assign pass_o = |(hit & mask_i & USED_MASK);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int PHY_BYTES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              dec_valid_o,
  output logic              dec_pass_o
);
  localparam int ADDR_BYTES = MAC_W / 8;

  logic [MAC_W-1:0]  own_mac, bssid, ra, ta;
  logic [FLAG_W-1:0] filt_mask;
  logic [7:2]        fc;
  logic              hdr_done, pass;

  rxf_cfg_regs i_regs (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .own_mac_o (own_mac),
    .bssid_o   (bssid),
    .mask_o    (filt_mask)
  );

  rxf_hdr_parser #(.PHY_BYTES(PHY_BYTES), .ADDR_BYTES(ADDR_BYTES)) i_parser (
    .clk_i, .rst_ni,
    .start_i (frame_start_i),
    .valid_i (byte_valid_i),
    .data_i  (byte_i),
    .fc_o    (fc),
    .ra_o    (ra),
    .ta_o    (ta),
    .done_o  (hdr_done)
  );

  rxf_classify i_cls (
    .fc_i      (fc),
    .ra_i      (ra),
    .ta_i      (ta),
    .own_mac_i (own_mac),
    .bssid_i   (bssid),
    .mask_i    (filt_mask),
    .pass_o    (pass)
  );

  assign dec_valid_o = hdr_done;
  assign dec_pass_o  = hdr_done && pass;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic              dec_valid_o,
  input logic              dec_pass_o,
  input logic [FLAG_W-1:0] filt_mask
);
  // R2: decision strobe lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);

  // R2: decision follows an accepted byte
  a_r2_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i));

  // R2: pass only qualifies a decision
  a_r2_pass_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_pass_o |-> dec_valid_o);

  // R10: monitor passes everything
  a_r10_monitor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && filt_mask[F_MONITOR]) |-> dec_pass_o);

  // R1, R11: no usable category enabled -> drop
  a_r11_unused_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && ((filt_mask & USED_MASK) == '0)) |-> !dec_pass_o);
endmodule

bind rx_addr_filter rxf_checker i_rxf_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .dec_valid_o  (dec_valid_o),
  .dec_pass_o   (dec_pass_o),
  .filt_mask    (filt_mask)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        frame_start_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        dec_valid_o, dec_pass_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rx_addr_filter i_rx_addr_filter (.*);

  localparam logic [47:0] OWN = 48'h5e4d3c2b1a02;
  localparam logic [47:0] BSS = 48'h665544332211;
  localparam logic [47:0] BC1 = '1;
  localparam logic [47:0] MC4 = 48'h77665e0001ab & 48'hffffff_ffffff;
  localparam logic [47:0] MC6 = 48'h090807063333;

  logic [47:0] cur_own = '0, cur_bss = '0;
  logic [13:0] cur_mask = '0;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic logic model(logic [7:0] fc, logic [47:0] ra, logic [47:0] ta);
    logic [1:0] t; logic [3:0] s; logic [13:0] h;
    t = fc[3:2]; s = fc[7:4]; h = '0;
    h[1]  = (ra[7:0] == 8'h01 && ra[15:8] == 8'h00 && ra[23:16] == 8'h5e) ||
            (ra[7:0] == 8'h33 && ra[15:8] == 8'h33);
    h[4]  = t == 0 && (s == 8 || s == 5);
    h[5]  = t == 1;
    h[6]  = t == 2 && ta != cur_bss;
    h[7]  = t == 1 && s == 10;
    h[8]  = t == 0 && s == 4;
    h[9]  = ra == cur_own;
    h[10] = ra == '1;
    h[11] = ra == '0;
    h[12] = t == 0 && s == 8 && ta == cur_bss;
    h[13] = 1'b1;
    h[0] = 0; h[2] = 0; h[3] = 0;
    return |(h & cur_mask);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic set_cfg(input logic [47:0] own, input logic [47:0] bss, input logic [13:0] m);
    wr(3'd0, own[31:0]);
    wr(3'd1, {16'hbeef, own[47:32]});
    wr(3'd2, bss[31:0]);
    wr(3'd3, {16'h1234, bss[47:32]});
    wr(3'd4, {18'h3ffff, m});
    cur_own = own; cur_bss = bss; cur_mask = m;
  endtask

  function automatic logic [7:0] hbyte(int i, logic [7:0] fc, logic [47:0] ra, logic [47:0] ta);
    if (i == 5) return fc;
    if (i >= 9 && i <= 14) return ra[8*(i-9) +: 8];
    if (i >= 15) return ta[8*(i-15) +: 8];
    return 8'($urandom);
  endfunction

  // sends bytes 0..nb-1; checks decision when nb covers full header
  task automatic send(input logic [7:0] fc, input logic [47:0] ra, input logic [47:0] ta,
                      input string req, input int nb = 21, input bit gaps = 1);
    logic exp;
    exp = model(fc, ra, ta);
    @(negedge clk_i);
    frame_start_i = 1;
    @(negedge clk_i);
    frame_start_i = 0;
    for (int i = 0; i < nb; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk_i);
      byte_valid_i = 1; byte_i = hbyte(i, fc, ra, ta);
      @(negedge clk_i);
      byte_valid_i = 0;
      if (i == 19) chk(dec_valid_o, 1'b0, "R2", "no early decision");
      if (i == 20) begin
        chk(dec_valid_o, 1'b1, "R2", "decision strobe");
        chk(dec_pass_o, exp, req, "pass bit");
      end
    end
    @(negedge clk_i);
    chk(dec_valid_o, 1'b0, "R2", "strobe one cycle");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(dec_valid_o, 1'b0, "R1", "valid in reset");
    chk(dec_pass_o, 1'b0, "R1", "pass in reset");
    rst_ni = 1;
    // R1: zero mask drops broadcast and anything else
    send(8'h80, BC1, BSS, "R1");
    send(8'h08, 48'h0, 48'h0, "R1");

    // R3, R12: own MAC byte order, high-word upper bits ignored
    set_cfg(OWN, BSS, 14'h0200);
    send(8'h08, OWN, BSS, "R3");
    send(8'h08, OWN ^ 48'h010000000000, BSS, "R3");
    send(8'h08, OWN ^ 48'h000000000001, BSS, "R12");

    // R4
    set_cfg(OWN, BSS, 14'h0400);
    send(8'h08, BC1, BSS, "R4");
    send(8'h08, 48'h0, BSS, "R4");
    set_cfg(OWN, BSS, 14'h0800);
    send(8'h08, 48'h0, BSS, "R4");
    send(8'h08, BC1, BSS, "R4");

    // R5
    set_cfg(OWN, BSS, 14'h0002);
    send(8'h08, 48'h3a2b1c5e0001, BSS, "R5");
    send(8'h08, MC6, BSS, "R5");
    send(8'h08, 48'h3a2b1c5f0001, BSS, "R5");
    send(8'h08, 48'h090807063332, BSS, "R5");

    // R6
    set_cfg(OWN, BSS, 14'h1000);
    send(8'h80, BC1, BSS, "R6");
    send(8'h80, BC1, BSS ^ 48'h800000000000, "R6");
    send(8'h50, OWN, BSS, "R6");

    // R7
    set_cfg(OWN, BSS, 14'h0010);
    send(8'h80, BC1, 48'h123456789abc, "R7");
    send(8'h50, OWN, 48'h123456789abc, "R7");
    send(8'h08, OWN, 48'h123456789abc, "R7");

    // R8
    set_cfg(OWN, BSS, 14'h0020);
    send(8'hd4, OWN, BSS, "R8");
    send(8'h40, BC1, BSS, "R8");
    set_cfg(OWN, BSS, 14'h0080);
    send(8'ha4, OWN, BSS, "R8");
    send(8'hd4, OWN, BSS, "R8");
    set_cfg(OWN, BSS, 14'h0100);
    send(8'h40, BC1, BSS, "R8");
    send(8'h80, BC1, BSS, "R8");

    // R9
    set_cfg(OWN, BSS, 14'h0040);
    send(8'h08, OWN, 48'hfedcba987654, "R9");
    send(8'h08, OWN, BSS, "R9");
    send(8'h80, OWN, 48'hfedcba987654, "R9");

    // R10
    set_cfg(OWN, BSS, 14'h2000);
    send(8'h08, 48'h445566778899, 48'hfedcba987654, "R10");
    send(8'h2c, OWN, BSS, "R10");

    // R11: only unsupported bits set
    set_cfg(OWN, BSS, 14'h000d);
    send(8'h80, BC1, BSS, "R11");
    send(8'h08, 48'h3a2b1c5e0001, BSS, "R11");
    send(8'hd4, OWN, BSS, "R11");

    // R13: abandon a partial header, restart
    set_cfg(OWN, BSS, 14'h0200);
    begin
      @(negedge clk_i);
      frame_start_i = 1;
      @(negedge clk_i);
      frame_start_i = 0;
      for (int i = 0; i < 12; i++) begin
        byte_valid_i = 1; byte_i = hbyte(i, 8'h08, OWN, BSS);
        @(negedge clk_i);
        byte_valid_i = 0;
      end
    end
    send(8'h08, 48'h010203040506, BSS, "R13");
    send(8'h08, OWN, BSS, "R13", 21, 0);

    // random phase
    for (int n = 0; n < 300; n++) begin
      logic [47:0] ra, ta, pool[6];
      logic [7:0] fcs[8];
      logic [7:0] fc;
      pool[0] = OWN; pool[1] = BC1; pool[2] = '0; pool[3] = 48'h3a2b1c5e0001;
      pool[4] = MC6; pool[5] = {$urandom, 16'($urandom)};
      fcs[0] = 8'h80; fcs[1] = 8'h50; fcs[2] = 8'h40; fcs[3] = 8'hd4;
      fcs[4] = 8'ha4; fcs[5] = 8'h08; fcs[6] = 8'h88; fcs[7] = 8'($urandom);
      if (n % 25 == 0) begin
        logic [13:0] m;
        m = 14'($urandom);
        if ($urandom_range(0, 1)) m[13] = 0;
        set_cfg(OWN, BSS, m);
      end
      ra = pool[$urandom_range(0, 5)];
      ta = $urandom_range(0, 1) ? BSS : {$urandom, 16'($urandom)};
      fc = fcs[$urandom_range(0, 7)];
      send(fc, ra, ta, "RND");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule